// File: doc/BRIEF.md
# Low-Power Mode Wake Controller

This block decides when a processor subsystem drops into a low-power state and when it comes back out. Software programs a byte-wide control register. It picks the low-power mode taken on a stop request, the clock-stop code applied while in full stop, and the regulator standby flavour used on a power-down request. A second small register holds an encoded minimum interrupt priority. Only pending interrupts at or above that priority end the low-power state.

When the processor strobes a stop request, the controller latches the selected mode and holds it on its mode output until a qualifying interrupt level arrives. It then drops back to the run state and emits a single-cycle wake pulse. Separately, a power-down request drives the standby outputs. The regulator's voltage-detect circuit is kept alive only when both the register's select bit and an external enable allow it.

Top module: `lpwake_ctrl`

## Requirements
- R1: After reset, the control register (reg_addr=0) reads 0x02 and the threshold register (reg_addr=1) reads 0x00. lp_active, lp_mode, clk_stop, wake_pulse, stby_on and stby_lvd_on are all 0.
- R2: In the control register only bits 7:6 (mode), 4:3 (clock-stop code) and 1 (standby select) are writable. Bits 5, 2 and 0 read 0 and ignore writes. In the threshold register only bits 2:0 are writable, and bits 7:3 read 0.
- R3: The mode encodings are 00 run, 01 idle, 10 doze and 11 stop. A stop_req high at a clock edge while not in low power, with a nonzero mode field, sets lp_active=1 and lp_mode to the sampled mode after that edge. With mode field 00, stop_req causes no entry.
- R4: The mode bits can be written and read back while in low power, and such a write does not change lp_mode for the current entry.
- R5: stop_req is ignored while lp_active is 1.
- R6: The minimum waking level is decoded from threshold code t: t=0 gives 1, t=1..5 gives t+1, and t=6 or 7 gives 7. A valid level at or above the minimum wakes the block.
- R7: An irq_level of 0, or irq_valid low, never wakes the block, even with threshold 0.
- R8: At the edge where a qualifying level is present in low power, the block clears lp_active, returns lp_mode to 00 and raises wake_pulse for exactly one cycle.
- R9: clk_stop equals control bits 4:3 while lp_active is 1 with lp_mode 11, and is 00 at all other times.
- R10: stby_on follows pwr_down_req one clock later. With lvd_en_ext=1, stby_lvd_on follows (pwr_down_req AND standby select bit 1) one clock later.
- R11: When lvd_en_ext is 0, stby_lvd_on is 0 one clock later regardless of the standby select bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 selects control register, 1 selects threshold register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the addressed register |
| stop_req | input | 1 | Stop request strobe from the processor |
| irq_valid | input | 1 | Pending interrupt level is valid |
| irq_level | input | 3 | Pending interrupt priority level |
| pwr_down_req | input | 1 | Regulator power-down request |
| lvd_en_ext | input | 1 | External enable for voltage detection |
| lp_active | output | 1 | Block is in a low-power state |
| lp_mode | output | 2 | Current mode (00 while running) |
| clk_stop | output | 2 | Clock-stop code applied during full stop |
| wake_pulse | output | 1 | One-cycle pulse on wake-up |
| stby_on | output | 1 | Regulator standby requested |
| stby_lvd_on | output | 1 | Voltage detection kept on during standby |

## Verification
Several properties are checked on every cycle. The reserved bits always read zero, the wake pulse never lasts more than one cycle, and no wake occurs without a nonzero valid level. The clock-stop code appears only in full stop, a stop request during low power leaves the mode untouched, and voltage detection never stays on without standby or against a cleared external enable. The exact threshold decoding can only be shown by the bench's table walk over threshold and level pairs. The same holds for sampling of the mode at entry when the register changes afterwards, the reset values, and the masking of written data.

// File: rtl/lpwake_pkg.sv
package lpwake_pkg;
  localparam int CTRL_W = 8;

  typedef enum logic [1:0] {
    LPM_RUN  = 2'b00,
    LPM_IDLE = 2'b01,
    LPM_DOZE = 2'b10,
    LPM_STOP = 2'b11
  } lpm_e;

  localparam logic [CTRL_W-1:0] CTRL_RST  = 8'h02;
  localparam logic [CTRL_W-1:0] CTRL_MASK = 8'hDA;
  localparam int MODE_LSB = 6;
  localparam int CSTP_LSB = 3;
  localparam int STBY_BIT = 1;
endpackage

// File: rtl/lpwake_regs.sv
module lpwake_regs
  import lpwake_pkg::*;
#(
  parameter int LVL_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              addr,
  input  logic [CTRL_W-1:0] wdata,
  output logic [CTRL_W-1:0] rdata,
  output logic [1:0]        mode_sel,
  output logic [1:0]        cstp_sel,
  output logic              stby_sel,
  output logic [LVL_W-1:0]  thr
);
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [LVL_W-1:0]  thr_q, thr_d;
  logic              ctrl_en, thr_en;

  assign ctrl_en = wr_en && !addr;
  assign thr_en  = wr_en && addr;

  always_comb begin
    ctrl_d = ctrl_q;
    thr_d  = thr_q;
    if (ctrl_en) ctrl_d = wdata & CTRL_MASK;
    if (thr_en)  thr_d  = wdata[LVL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
      thr_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      thr_q  <= thr_d;
    end
  end

  always_comb begin
    if (addr) rdata = {{(CTRL_W-LVL_W){1'b0}}, thr_q};
    else      rdata = ctrl_q;
  end

  assign mode_sel = ctrl_q[MODE_LSB+1:MODE_LSB];
  assign cstp_sel = ctrl_q[CSTP_LSB+1:CSTP_LSB];
  assign stby_sel = ctrl_q[STBY_BIT];
  assign thr      = thr_q;
endmodule

// File: rtl/lpwake_filter.sv
module lpwake_filter #(
  parameter int LVL_W = 3
) (
  input  logic [LVL_W-1:0] thr,
  input  logic [LVL_W-1:0] level,
  input  logic             valid,
  output logic             hit
);
  localparam logic [LVL_W-1:0] LVL_MAX = {LVL_W{1'b1}};
  localparam logic [LVL_W-1:0] THR_TOP = LVL_MAX - 1'b1;

  logic [LVL_W-1:0] min_lvl;

  always_comb begin
    if (thr == '0)           min_lvl = {{(LVL_W-1){1'b0}}, 1'b1};
    else if (thr >= THR_TOP) min_lvl = LVL_MAX;
    else                     min_lvl = thr + 1'b1;
  end

  assign hit = valid && (level != '0) && (level >= min_lvl);
endmodule

// File: rtl/lpwake_fsm.sv
module lpwake_fsm
  import lpwake_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stop_req,
  input  logic [1:0] mode_sel,
  input  logic [1:0] cstp_sel,
  input  logic       hit,
  output logic       active,
  output logic [1:0] mode,
  output logic [1:0] clk_stop,
  output logic       wake
);
  logic active_q, active_d;
  lpm_e mode_q, mode_d;
  logic wake_q, wake_d;

  always_comb begin
    active_d = active_q;
    mode_d   = mode_q;
    wake_d   = 1'b0;
    if (!active_q) begin
      if (stop_req && (lpm_e'(mode_sel) != LPM_RUN)) begin
        active_d = 1'b1;
        mode_d   = lpm_e'(mode_sel);
      end
    end else if (hit) begin
      active_d = 1'b0;
      mode_d   = LPM_RUN;
      wake_d   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      mode_q   <= LPM_RUN;
      wake_q   <= 1'b0;
    end else begin
      active_q <= active_d;
      mode_q   <= mode_d;
      wake_q   <= wake_d;
    end
  end

  assign active   = active_q;
  assign mode     = mode_q;
  assign wake     = wake_q;
  assign clk_stop = (active_q && mode_q == LPM_STOP) ? cstp_sel : 2'b00;
endmodule

// File: rtl/lpwake_ctrl.sv
module lpwake_ctrl
  import lpwake_pkg::*;
#(
  parameter int LVL_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic              reg_addr,
  input  logic [CTRL_W-1:0] reg_wdata,
  output logic [CTRL_W-1:0] reg_rdata,
  input  logic              stop_req,
  input  logic              irq_valid,
  input  logic [LVL_W-1:0]  irq_level,
  input  logic              pwr_down_req,
  input  logic              lvd_en_ext,
  output logic              lp_active,
  output logic [1:0]        lp_mode,
  output logic [1:0]        clk_stop,
  output logic              wake_pulse,
  output logic              stby_on,
  output logic              stby_lvd_on
);
  logic [1:0]       mode_sel, cstp_sel;
  logic             stby_sel, hit;
  logic [LVL_W-1:0] thr;
  logic             stby_q, stby_d, lvd_q, lvd_d;

  lpwake_regs #(.LVL_W(LVL_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .mode_sel(mode_sel),
    .cstp_sel(cstp_sel), .stby_sel(stby_sel), .thr(thr)
  );

  lpwake_filter #(.LVL_W(LVL_W)) u_filter (
    .thr(thr), .level(irq_level), .valid(irq_valid), .hit(hit)
  );

  lpwake_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .mode_sel(mode_sel),
    .cstp_sel(cstp_sel), .hit(hit), .active(lp_active), .mode(lp_mode),
    .clk_stop(clk_stop), .wake(wake_pulse)
  );

  always_comb begin
    stby_d = pwr_down_req;
    lvd_d  = pwr_down_req && stby_sel && lvd_en_ext;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stby_q <= 1'b0;
      lvd_q  <= 1'b0;
    end else begin
      stby_q <= stby_d;
      lvd_q  <= lvd_d;
    end
  end

  assign stby_on     = stby_q;
  assign stby_lvd_on = lvd_q;
endmodule

// File: rtl/lpwake_chk.sv
module lpwake_chk
  import lpwake_pkg::*;
#(
  parameter int LVL_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_addr,
  input logic [CTRL_W-1:0] reg_rdata,
  input logic              stop_req,
  input logic              irq_valid,
  input logic [LVL_W-1:0]  irq_level,
  input logic              pwr_down_req,
  input logic              lvd_en_ext,
  input logic              lp_active,
  input logic [1:0]        lp_mode,
  input logic [1:0]        clk_stop,
  input logic              wake_pulse,
  input logic              stby_on,
  input logic              stby_lvd_on
);
  assert_rsvd_ctrl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_addr |-> ((reg_rdata & ~CTRL_MASK) == '0));
  assert_rsvd_thr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr |-> (reg_rdata[CTRL_W-1:LVL_W] == '0));
  assert_stop_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_active && stop_req) |=> (wake_pulse || lp_mode == $past(lp_mode)));
  assert_no_wake_invalid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_active && (!irq_valid || irq_level == '0)) |=> (lp_active && !wake_pulse));
  assert_wake_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |=> !wake_pulse);
  assert_wake_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> (!lp_active && lp_mode == 2'b00 && $past(lp_active)));
  assert_clkstop_stop_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_stop != 2'b00) |-> (lp_active && lp_mode == 2'b11));
  assert_stby_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down_req |=> stby_on);
  assert_lvd_needs_stby_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stby_lvd_on |-> stby_on);
  assert_lvd_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !lvd_en_ext |=> !stby_lvd_on);
endmodule

bind lpwake_ctrl lpwake_chk #(.LVL_W(LVL_W)) u_chk (
  .clk, .rst_n, .reg_addr, .reg_rdata, .stop_req, .irq_valid, .irq_level,
  .pwr_down_req, .lvd_en_ext, .lp_active, .lp_mode, .clk_stop,
  .wake_pulse, .stby_on, .stby_lvd_on
);

// File: tb/lpwake_ctrl_bench.sv
module lpwake_ctrl_bench;
  logic       clk, rst_n;
  logic       reg_wr_en, reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       stop_req, irq_valid, pwr_down_req, lvd_en_ext;
  logic [2:0] irq_level;
  logic       lp_active, wake_pulse, stby_on, stby_lvd_on;
  logic [1:0] lp_mode, clk_stop;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  lpwake_ctrl u_lpwake_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .stop_req(stop_req),
    .irq_valid(irq_valid), .irq_level(irq_level), .pwr_down_req(pwr_down_req),
    .lvd_en_ext(lvd_en_ext), .lp_active(lp_active), .lp_mode(lp_mode),
    .clk_stop(clk_stop), .wake_pulse(wake_pulse), .stby_on(stby_on),
    .stby_lvd_on(stby_lvd_on)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // {threshold code, level, expected wake}
  localparam logic [6:0] VEC [13] = '{
    {3'd0, 3'd0, 1'b0}, {3'd0, 3'd1, 1'b1}, {3'd1, 3'd1, 1'b0},
    {3'd1, 3'd2, 1'b1}, {3'd2, 3'd2, 1'b0}, {3'd2, 3'd3, 1'b1},
    {3'd3, 3'd4, 1'b1}, {3'd4, 3'd4, 1'b0}, {3'd5, 3'd6, 1'b1},
    {3'd5, 3'd5, 1'b0}, {3'd6, 3'd6, 1'b0}, {3'd7, 3'd7, 1'b1},
    {3'd6, 3'd7, 1'b1}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic enter();
    @(negedge clk); stop_req = 1'b1;
    @(negedge clk); stop_req = 1'b0;
  endtask

  task automatic wake_up();
    @(negedge clk); irq_valid = 1'b1; irq_level = 3'd7;
    @(negedge clk); irq_valid = 1'b0; irq_level = 3'd0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
    end
  end

  initial begin
    logic [7:0] d;
    rst_n = 1'b0; reg_wr_en = 1'b0; reg_addr = 1'b0; reg_wdata = '0;
    stop_req = 1'b0; irq_valid = 1'b0; irq_level = '0;
    pwr_down_req = 1'b0; lvd_en_ext = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(1'b0, d); chk("R1 ctrl", d, 8'h02);
    rd(1'b1, d); chk("R1 thr", d, 8'h00);
    chk("R1 outs", {lp_active, lp_mode, clk_stop, wake_pulse, stby_on, stby_lvd_on}, 8'h00);

    // Table walk: R6 threshold decoding, R7 level zero, R8 wake
    for (int i = 0; i < 13; i++) begin
      wr(1'b1, {5'd0, VEC[i][6:4]});
      wr(1'b0, 8'hC0);
      enter();
      chk("R3 entry", {6'd0, lp_mode}, 8'h03);
      @(negedge clk); irq_valid = 1'b1; irq_level = VEC[i][3:1];
      @(negedge clk); irq_valid = 1'b0; irq_level = 3'd0;
      chk("R6 wake vs threshold", {7'd0, wake_pulse}, {7'd0, VEC[i][0]});
      chk("R6 active after", {7'd0, lp_active}, {7'd0, ~VEC[i][0]});
      if (VEC[i][0]) begin
        chk("R8 mode back to run", {6'd0, lp_mode}, 8'h00);
        @(negedge clk);
        chk("R8 single cycle pulse", {7'd0, wake_pulse}, 8'h00);
      end else begin
        wake_up();
      end
    end

    // R2 reserved bits
    wr(1'b0, 8'hFF); rd(1'b0, d); chk("R2 ctrl mask", d, 8'hDA);
    wr(1'b1, 8'hFF); rd(1'b1, d); chk("R2 thr mask", d, 8'h07);

    // R3 mode 00 gives no entry
    wr(1'b0, 8'h00); enter();
    chk("R3 no entry mode 00", {7'd0, lp_active}, 8'h00);

    // R4 mode sampled at entry, writable while low power
    wr(1'b0, 8'h40); enter();
    chk("R3 idle entry", {6'd0, lp_mode}, 8'h01);
    wr(1'b0, 8'h80); rd(1'b0, d);
    chk("R4 readback in low power", d, 8'h80);
    chk("R4 mode held", {6'd0, lp_mode}, 8'h01);

    // R5 stop request ignored while active
    enter();
    chk("R5 mode unchanged", {6'd0, lp_mode}, 8'h01);
    chk("R5 still active", {7'd0, lp_active}, 8'h01);

    // R7 irq_valid low with top level
    @(negedge clk); irq_level = 3'd7;
    @(negedge clk); irq_level = 3'd0;
    chk("R7 invalid level ignored", {7'd0, lp_active}, 8'h01);
    wake_up();

    // R9 clock-stop code
    wr(1'b0, 8'hD8);
    chk("R9 run clk_stop", {6'd0, clk_stop}, 8'h00);
    enter();
    chk("R9 stop clk_stop", {6'd0, clk_stop}, 8'h03);
    wake_up();
    chk("R9 after wake", {6'd0, clk_stop}, 8'h00);
    wr(1'b0, 8'h98); enter();
    chk("R9 doze clk_stop", {6'd0, clk_stop}, 8'h00);
    wake_up();

    // R10/R11 standby
    wr(1'b0, 8'h02);
    @(negedge clk); pwr_down_req = 1'b1; lvd_en_ext = 1'b1;
    @(negedge clk);
    chk("R10 pseudo standby", {6'd0, stby_on, stby_lvd_on}, 8'h03);
    lvd_en_ext = 1'b0;
    @(negedge clk);
    chk("R11 ext enable off", {6'd0, stby_on, stby_lvd_on}, 8'h02);
    lvd_en_ext = 1'b1;
    wr(1'b0, 8'h00);
    @(negedge clk);
    chk("R10 plain standby", {6'd0, stby_on, stby_lvd_on}, 8'h02);
    pwr_down_req = 1'b0;
    @(negedge clk);
    chk("R10 release", {6'd0, stby_on, stby_lvd_on}, 8'h00);

    done = 1'b1;
    summary();
  end
endmodule